// File: doc/BRIEF.md
# Event Tag Sequencer with Readout Busy Handshake

This block is the master sequencer that labels each accepted level-1 trigger with a 16-bit event word and broadcasts that word to several readout controllers. When a trigger is accepted, it raises a global busy output and advances a 12-bit event counter. It then places the counter and a 4-bit type code on a data port and pulses a strobe. It keeps busy high until every readout controller has raised its own busy line and then dropped it again.

A separate request starts a run of synchronisation broadcasts with type code 1111. Their count is set by an input and is used to push events out of a pipelined readout. Triggers that arrive while the sequencer is busy are discarded and counted. A per-controller watchdog sets a sticky error flag if any readout busy line stays high for too long.

Top module: `evtag_seq`

## Requirements
- R1: During and after synchronous reset, `gen_busy`, `evt_strobe`, `drop_count`, `timeout_err` and `evt_word` are all 0. The internal event number is 0, so the first broadcast after reset carries number 1.
- R2: In every broadcast, `evt_word[11:0]` holds the event number and `evt_word[15:12]` holds the type. For a trigger, the type is the value of `special_in` in the accepting cycle, so it is 0000 when no special bit is set.
- R3: If `l1_accept` is sampled while idle, `gen_busy` is high from the next cycle. `evt_word` changes one cycle later. `evt_strobe` is high for exactly one cycle, in the cycle after that, and the word is unchanged while the strobe is high.
- R4: Each broadcast carries the previous event number plus one, and the number wraps from 4095 to 0.
- R5: `gen_busy` stays high until every bit of `roc_busy` has been seen high since the broadcast and all bits are low. It then falls in the next cycle.
- R6: A `sync_req` sampled while idle produces N back-to-back broadcasts of type 1111, with `gen_busy` high throughout. N is `sync_count` limited to the range 1 to 8: 0 gives 1 and values above 8 give 8. Each broadcast after the first starts when the previous handshake ends and uses the same timing as R3.
- R7: An `l1_accept` sampled while `gen_busy` is high produces no broadcast and does not advance the event number. It adds one to `drop_count`, which saturates at its maximum.
- R8: If `l1_accept` and `sync_req` arrive in the same idle cycle, the trigger wins and the sync request is discarded. A `sync_req` sampled while busy has no effect.
- R9: `timeout_err` is set once a `roc_busy` bit has been sampled high on more than `busy_limit` consecutive clock edges. It becomes visible after the edge with the (`busy_limit`+1)-th high sample and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l1_accept | input | 1 | Level-1 trigger pulse |
| sync_req | input | 1 | Starts a run of sync broadcasts |
| special_in | input | 4 | Special-event bit pattern used as the type |
| sync_count | input | 4 | Requested number of sync broadcasts |
| busy_limit | input | 16 | Watchdog limit in cycles |
| roc_busy | input | 3 | Busy line from each readout controller |
| gen_busy | output | 1 | Generator busy |
| evt_word | output | 16 | Type (15:12) and event number (11:0) |
| evt_strobe | output | 1 | One-cycle data-valid strobe |
| drop_count | output | 16 | Number of triggers discarded while busy |
| timeout_err | output | 1 | Sticky watchdog error |

## Verification
The hardest case to reach is the counter wrap from 4095 to 0, because it takes more than four thousand complete handshakes. The bench reaches it by running a short loop of minimal handshakes with all busy lines pulsed together, and then checks the last two broadcasts in full. Partial handshakes are also difficult, because a controller that never raises busy has to hold the sequencer busy. The bench creates this case by leaving one busy bit low and then releasing it later.

// File: rtl/evtag_seq.sv
module evtag_seq #(
  parameter int NROC    = 3,
  parameter int NUMW    = 12,
  parameter int TYPEW   = 4,
  parameter int SYNCW   = 4,
  parameter int MAXSYNC = 8,
  parameter int DROPW   = 16,
  parameter int TOW     = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   l1_accept,
  input  logic                   sync_req,
  input  logic [TYPEW-1:0]       special_in,
  input  logic [SYNCW-1:0]       sync_count,
  input  logic [TOW-1:0]         busy_limit,
  input  logic [NROC-1:0]        roc_busy,
  output logic                   gen_busy,
  output logic [NUMW+TYPEW-1:0]  evt_word,
  output logic                   evt_strobe,
  output logic [DROPW-1:0]       drop_count,
  output logic                   timeout_err
);
  localparam int LW = $clog2(MAXSYNC + 1);
  localparam logic [TYPEW-1:0] SYNC_TYPE = '1;

  typedef enum logic [2:0] {S_IDLE, S_INC, S_HOLD, S_WAIT} st_t;

  st_t              state;
  logic [NUMW-1:0]  num;
  logic [TYPEW-1:0] type_q;
  logic [NROC-1:0]  seen;
  logic [LW-1:0]    left;
  logic [LW-1:0]    sync_n;
  logic [NROC-1:0]  seen_n;
  logic [NUMW-1:0]  num_n;
  logic             release_ok;
  logic [NROC-1:0]  wd_hit;

  assign num_n      = num + 1'b1;
  assign seen_n     = seen | roc_busy;
  assign release_ok = (&seen_n) && (roc_busy == '0);
  assign sync_n     = (sync_count == '0) ? LW'(1) :
                      (sync_count > SYNCW'(MAXSYNC)) ? LW'(MAXSYNC) : LW'(sync_count);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      gen_busy   <= 1'b0;
      num        <= '0;
      evt_word   <= '0;
      evt_strobe <= 1'b0;
      type_q     <= '0;
      seen       <= '0;
      left       <= '0;
      drop_count <= '0;
    end else begin
      evt_strobe <= 1'b0;
      if (l1_accept && gen_busy && drop_count != '1)
        drop_count <= drop_count + 1'b1;
      case (state)
        S_IDLE: begin
          if (l1_accept) begin
            gen_busy <= 1'b1;
            type_q   <= special_in;
            left     <= LW'(1);
            state    <= S_INC;
          end else if (sync_req) begin
            gen_busy <= 1'b1;
            type_q   <= SYNC_TYPE;
            left     <= sync_n;
            state    <= S_INC;
          end
        end
        S_INC: begin
          num      <= num_n;
          evt_word <= {type_q, num_n};
          seen     <= '0;
          state    <= S_HOLD;
        end
        S_HOLD: begin
          evt_strobe <= 1'b1;
          seen       <= seen_n;
          state      <= S_WAIT;
        end
        S_WAIT: begin
          seen <= seen_n;
          if (release_ok) begin
            if (left > LW'(1)) begin
              left  <= left - 1'b1;
              state <= S_INC;
            end else begin
              gen_busy <= 1'b0;
              state    <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NROC; i++) begin : g_wd
    logic [TOW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !roc_busy[i]) cnt <= '0;
      else if (cnt != '1)      cnt <= cnt + 1'b1;
    end
    assign wd_hit[i] = roc_busy[i] && (cnt >= busy_limit);
  end

  always_ff @(posedge clk) begin
    if (rst) timeout_err <= 1'b0;
    else if (|wd_hit) timeout_err <= 1'b1;
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    evt_strobe |=> !evt_strobe);
  a_r3_word_stable: assert property (@(posedge clk) disable iff (rst)
    evt_strobe |-> $stable(evt_word));
  a_r3_busy_at_strobe: assert property (@(posedge clk) disable iff (rst)
    evt_strobe |-> gen_busy);
  a_r5_release_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(gen_busy) |-> $past(roc_busy) == '0);
  a_r7_drop_step: assert property (@(posedge clk) disable iff (rst)
    (l1_accept && gen_busy && drop_count != '1) |=> drop_count == $past(drop_count) + 1'b1);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err);
endmodule

// File: tb/evtag_seq_test.sv
module evtag_seq_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        l1_accept = 0;
  logic        sync_req = 0;
  logic [3:0]  special_in = 0;
  logic [3:0]  sync_count = 0;
  logic [15:0] busy_limit = 16'd1000;
  logic [2:0]  roc_busy = 0;
  logic        gen_busy, evt_strobe, timeout_err;
  logic [15:0] evt_word, drop_count;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [11:0] exp_num = 0;

  always #2 clk = ~clk;

  evtag_seq uut (
    .clk(clk), .rst(rst), .l1_accept(l1_accept), .sync_req(sync_req),
    .special_in(special_in), .sync_count(sync_count), .busy_limit(busy_limit),
    .roc_busy(roc_busy), .gen_busy(gen_busy), .evt_word(evt_word),
    .evt_strobe(evt_strobe), .drop_count(drop_count), .timeout_err(timeout_err));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d exp=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // kind(1) : special(4) : sync count(4)
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 4'b0000, 4'd0}, {1'b0, 4'b1000, 4'd0}, {1'b0, 4'b0100, 4'd0},
    {1'b1, 4'b0000, 4'd3}, {1'b0, 4'b0010, 4'd0}, {1'b0, 4'b0001, 4'd0},
    {1'b1, 4'b0000, 4'd0}, {1'b1, 4'b0000, 4'd12}};

  // called just after the negedge where the trigger or release was driven
  task automatic bcast(input logic [3:0] typ);
    @(negedge clk);
    l1_accept = 0; sync_req = 0;
    chk(gen_busy == 1, "R3 busy", gen_busy, 1);
    @(negedge clk);
    exp_num = exp_num + 1'b1;
    chk(evt_word == {typ, exp_num}, "R2/R4 word", evt_word, {typ, exp_num});
    chk(evt_strobe == 0, "R3 strobe early", evt_strobe, 0);
    @(negedge clk);
    chk(evt_strobe == 1 && evt_word == {typ, exp_num}, "R3 strobe", evt_strobe, 1);
  endtask

  task automatic handshake(input bit last);
    roc_busy = 3'b001;
    @(negedge clk);
    chk(evt_strobe == 0, "R3 strobe width", evt_strobe, 0);
    roc_busy = 3'b011;
    @(negedge clk);
    roc_busy = 3'b111;
    @(negedge clk);
    roc_busy = 3'b100;
    @(negedge clk);
    chk(gen_busy == 1, "R5 held", gen_busy, 1);
    roc_busy = 3'b000;
    if (last) begin
      @(negedge clk);
      chk(gen_busy == 0, "R5 release", gen_busy, 0);
    end
  endtask

  task automatic fast_evt();
    l1_accept = 1;
    @(negedge clk); l1_accept = 0;
    @(negedge clk); @(negedge clk);
    roc_busy = 3'b111;
    @(negedge clk); roc_busy = 0;
    @(negedge clk);
    exp_num = exp_num + 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gen_busy == 0 && evt_strobe == 0 && evt_word == 0, "R1 outputs", evt_word, 0);
    chk(drop_count == 0 && timeout_err == 0, "R1 counters", drop_count, 0);
    rst = 0;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      int n;
      logic [3:0] typ;
      special_in = VEC[v][7:4];
      sync_count = VEC[v][3:0];
      if (VEC[v][8]) begin
        n = (VEC[v][3:0] == 0) ? 1 : (VEC[v][3:0] > 8) ? 8 : int'(VEC[v][3:0]);
        typ = 4'hF;
        sync_req = 1;
      end else begin
        n = 1;
        typ = VEC[v][7:4];
        l1_accept = 1;
      end
      for (int k = 0; k < n; k++) begin
        bcast(typ);
        handshake(k == n - 1);
      end
      repeat (2) @(negedge clk);
      chk(gen_busy == 0, VEC[v][8] ? "R6 sync count" : "R2 single", gen_busy, 0);
    end

    // R7: trigger during busy is dropped and does not advance the number
    special_in = 0;
    l1_accept = 1;
    bcast(4'h0);
    l1_accept = 1;
    @(negedge clk);
    l1_accept = 0;
    chk(drop_count == 1, "R7 drop count", drop_count, 1);
    handshake(1);
    l1_accept = 1;
    bcast(4'h0);
    handshake(1);

    // R8: simultaneous trigger and sync -> one trigger broadcast only
    special_in = 4'b1000; sync_count = 4'd4;
    l1_accept = 1; sync_req = 1;
    bcast(4'b1000);
    sync_req = 1;
    @(negedge clk);
    sync_req = 0;
    handshake(1);
    repeat (4) @(negedge clk);
    chk(gen_busy == 0 && evt_word[11:0] == exp_num, "R8 no sync", evt_word, exp_num);

    // R5: one controller never raises busy
    special_in = 0;
    l1_accept = 1;
    bcast(4'h0);
    roc_busy = 3'b011;
    @(negedge clk); roc_busy = 0;
    repeat (5) @(negedge clk);
    chk(gen_busy == 1, "R5 missing controller", gen_busy, 1);
    roc_busy = 3'b100;
    @(negedge clk); roc_busy = 0;
    @(negedge clk);
    chk(gen_busy == 0, "R5 late controller", gen_busy, 0);

    // R4: wrap of event number
    while (exp_num != 12'd4094) fast_evt();
    l1_accept = 1;
    bcast(4'h0);
    handshake(1);
    chk(evt_word[11:0] == 12'hFFF, "R4 top", evt_word[11:0], 12'hFFF);
    l1_accept = 1;
    bcast(4'h0);
    handshake(1);
    chk(evt_word[11:0] == 0, "R4 wrap", evt_word[11:0], 0);

    // R9: watchdog
    busy_limit = 16'd4;
    @(negedge clk);
    roc_busy = 3'b010;
    repeat (4) @(negedge clk);
    chk(timeout_err == 0, "R9 at limit", timeout_err, 0);
    roc_busy = 0;
    @(negedge clk);
    roc_busy = 3'b001;
    repeat (5) @(negedge clk);
    chk(timeout_err == 1, "R9 over limit", timeout_err, 1);
    roc_busy = 0;
    repeat (3) @(negedge clk);
    chk(timeout_err == 1, "R9 sticky", timeout_err, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(timeout_err == 0 && drop_count == 0, "R1 re-reset", timeout_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule